// File: doc/BRIEF.md
# MSR-Mapped Timestamp and Event Counters

This block keeps two counters that software reaches through a model-specific-register (MSR) read/write port. One is a 64-bit timestamp counter that steps once per core clock. It can be held while the core sits in system-management, debug-management or suspend mode, unless a per-mode permission input lets it keep running. The other is a 40-bit performance event counter. It steps when an external event strobe arrives with an event code that equals the code stored in a select register, and only while that register's enable bit is set.

The port takes an address, a 64-bit write value and separate write and read strobes. Read data is registered: it appears in the cycle after the read strobe and stays zero in any cycle that follows no read. The block decodes three addresses and ignores all others.

Top module: `msr_counter_bank`

## Requirements
- R1: After reset the timestamp counter, the event counter and the select register are all zero, and `msr_rdata` is zero.
- R2: A write to address 0x00000010 loads timestamp bits 31:0 from `msr_wdata[31:0]` and forces bits 63:32 to zero, whatever `msr_wdata[63:32]` holds.
- R3: In a cycle with no timestamp write and no suppression, the timestamp counter increases by one modulo 2^64, and the increment carries from bit 31 into bit 32.
- R4: The timestamp counter holds its value in any cycle where at least one mode input is high and the matching permission input is low. Modes: `in_sys_mgmt`/`run_in_sys_mgmt`, `in_dbg_mgmt`/`run_in_dbg_mgmt`, `in_suspend`/`run_in_suspend`.
- R5: A write to address 0x000000C1 loads event counter bits 39:0 from `msr_wdata[39:0]`. Bits 63:40 are reserved: writes to them are ignored and they read as zero.
- R6: The select register at address 0x00000186 stores the event code in bits 7:0 and the enable in bit 8. All its other bits read as zero.
- R7: The event counter increases by one in a cycle where `evt_valid` is high, the select enable is set and `evt_code` equals the stored code. In every other cycle without a write, it holds its value.
- R8: When a write and an increment fall in the same cycle on either counter, the counter takes the written value and skips that increment.
- R9: The event counter wraps from 0xFF_FFFF_FFFF to zero with no other effect.
- R10: `msr_rdata` shows the addressed register in the cycle after `msr_rd`, using its value from before any write in the same cycle. It is zero after a read of an unhandled address and in cycles that follow no read. A write to an unhandled address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msr_addr | input | 32 | MSR address for read or write |
| msr_wdata | input | 64 | Write value |
| msr_wr | input | 1 | Write strobe |
| msr_rd | input | 1 | Read strobe |
| msr_rdata | output | 64 | Registered read data |
| in_sys_mgmt | input | 1 | Core is in system-management mode |
| in_dbg_mgmt | input | 1 | Core is in debug-management mode |
| in_suspend | input | 1 | Core is in suspend mode |
| run_in_sys_mgmt | input | 1 | Timestamp may count in system-management mode |
| run_in_dbg_mgmt | input | 1 | Timestamp may count in debug-management mode |
| run_in_suspend | input | 1 | Timestamp may count in suspend mode |
| evt_valid | input | 1 | Event strobe |
| evt_code | input | 8 | Code of the event on this cycle |

## Verification
In every cycle, the assertions check the step rules of both counters: a timestamp load with its upper half cleared, the +1 step versus the hold under mode suppression, and an event step only on a qualified match. They also check that a write beats an increment, that the reserved event bits read as zero, and that read data is zero after an idle cycle or an unhandled address. The bench scenarios cover what needs history or exact values. These are the carry across bit 31, the event wrap, accumulated event counts under random code streams, random mode and permission mixes, read-before-write ordering, and writes to unhandled addresses that leave the real registers as they were.

// File: rtl/msr_cnt_pkg.sv
package msr_cnt_pkg;

    localparam int MSR_AW = 32;
    localparam int MSR_DW = 64;

    localparam logic [MSR_AW-1:0] ADDR_TSTAMP = 32'h0000_0010;
    localparam logic [MSR_AW-1:0] ADDR_EVCNT  = 32'h0000_00C1;
    localparam logic [MSR_AW-1:0] ADDR_EVSEL  = 32'h0000_0186;

    localparam int NUM_MODES = 3;
    localparam int MODE_SYS  = 0;
    localparam int MODE_DBG  = 1;
    localparam int MODE_SUSP = 2;

    localparam int EVSEL_CODE_W  = 8;
    localparam int EVSEL_EN_BIT  = 8;

    typedef struct packed {
        logic tstamp;
        logic evcnt;
        logic evsel;
    } msr_hit_t;

endpackage

// File: rtl/msr_tsc_unit.sv
module msr_tsc_unit #(
    parameter int CNT_W  = 64,
    parameter int LOAD_W = 32,
    parameter int NMODE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [LOAD_W-1:0] load_val,
    input  logic [NMODE-1:0]  mode_act,
    input  logic [NMODE-1:0]  mode_keep,
    output logic [CNT_W-1:0]  cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tsc_state_t;

    tsc_state_t st_d, st_q;
    logic [NMODE-1:0] blocked;
    logic halt;

    // one suppression term per operating mode
    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        assign blocked[m] = mode_act[m] & ~mode_keep[m];
    end

    assign halt = |blocked;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            // zero-extension clears everything above the load field
            st_d.cnt = CNT_W'(load_val);
        end else if (!halt) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/msr_evt_unit.sv
module msr_evt_unit #(
    parameter int CNT_W  = 40,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              sel_load,
    input  logic              sel_en_val,
    input  logic [CODE_W-1:0] sel_code_val,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    output logic [CNT_W-1:0]  cnt,
    output logic              sel_en,
    output logic [CODE_W-1:0] sel_code
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic [CODE_W-1:0] code;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic qualified;

    assign qualified = evt_valid && st_q.en && (evt_code == st_q.code);

    always_comb begin
        st_d = st_q;
        if (cnt_load) begin
            st_d.cnt = cnt_val;
        end else if (qualified) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (sel_load) begin
            st_d.en   = sel_en_val;
            st_d.code = sel_code_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign sel_en   = st_q.en;
    assign sel_code = st_q.code;

endmodule

// File: rtl/msr_rd_port.sv
module msr_rd_port #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  msr_cnt_pkg::msr_hit_t hit,
    input  logic [DW-1:0] tstamp_val,
    input  logic [DW-1:0] evcnt_val,
    input  logic [DW-1:0] evsel_val,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [DW-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d.data = '0;
        if (rd_en) begin
            unique case (1'b1)
                hit.tstamp: st_d.data = tstamp_val;
                hit.evcnt:  st_d.data = evcnt_val;
                hit.evsel:  st_d.data = evsel_val;
                default:    st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;

endmodule

// File: rtl/msr_counter_bank.sv
module msr_counter_bank
    import msr_cnt_pkg::*;
#(
    parameter int TSC_W     = 64,
    parameter int TSC_LD_W  = 32,
    parameter int EVT_W     = 40,
    parameter int CODE_W    = EVSEL_CODE_W,
    parameter int SEL_EN_B  = EVSEL_EN_BIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MSR_AW-1:0]   msr_addr,
    input  logic [MSR_DW-1:0]   msr_wdata,
    input  logic                msr_wr,
    input  logic                msr_rd,
    output logic [MSR_DW-1:0]   msr_rdata,
    input  logic                in_sys_mgmt,
    input  logic                in_dbg_mgmt,
    input  logic                in_suspend,
    input  logic                run_in_sys_mgmt,
    input  logic                run_in_dbg_mgmt,
    input  logic                run_in_suspend,
    input  logic                evt_valid,
    input  logic [CODE_W-1:0]   evt_code
);

    localparam int RSV_W = MSR_DW - EVT_W;

    msr_hit_t             hit;
    logic [NUM_MODES-1:0] mode_act;
    logic [NUM_MODES-1:0] mode_keep;
    logic [TSC_W-1:0]     tsc_cnt;
    logic [EVT_W-1:0]     evt_cnt;
    logic                 sel_en;
    logic [CODE_W-1:0]    sel_code;
    logic [MSR_DW-1:0]    sel_view;
    logic                 unused_wdata_hi;

    assign hit.tstamp = (msr_addr == ADDR_TSTAMP);
    assign hit.evcnt  = (msr_addr == ADDR_EVCNT);
    assign hit.evsel  = (msr_addr == ADDR_EVSEL);

    assign mode_act[MODE_SYS]   = in_sys_mgmt;
    assign mode_act[MODE_DBG]   = in_dbg_mgmt;
    assign mode_act[MODE_SUSP]  = in_suspend;
    assign mode_keep[MODE_SYS]  = run_in_sys_mgmt;
    assign mode_keep[MODE_DBG]  = run_in_dbg_mgmt;
    assign mode_keep[MODE_SUSP] = run_in_suspend;

    // reserved write bits have no destination
    assign unused_wdata_hi = ^msr_wdata[MSR_DW-1:EVT_W];

    msr_tsc_unit #(
        .CNT_W  (TSC_W),
        .LOAD_W (TSC_LD_W),
        .NMODE  (NUM_MODES)
    ) u_tsc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (msr_wr && hit.tstamp),
        .load_val  (msr_wdata[TSC_LD_W-1:0]),
        .mode_act  (mode_act),
        .mode_keep (mode_keep),
        .cnt       (tsc_cnt)
    );

    msr_evt_unit #(
        .CNT_W  (EVT_W),
        .CODE_W (CODE_W)
    ) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_load     (msr_wr && hit.evcnt),
        .cnt_val      (msr_wdata[EVT_W-1:0]),
        .sel_load     (msr_wr && hit.evsel),
        .sel_en_val   (msr_wdata[SEL_EN_B]),
        .sel_code_val (msr_wdata[CODE_W-1:0]),
        .evt_valid    (evt_valid),
        .evt_code     (evt_code),
        .cnt          (evt_cnt),
        .sel_en       (sel_en),
        .sel_code     (sel_code)
    );

    always_comb begin
        sel_view               = '0;
        sel_view[CODE_W-1:0]   = sel_code;
        sel_view[SEL_EN_B]     = sel_en;
    end

    msr_rd_port #(
        .DW (MSR_DW)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (msr_rd),
        .hit        (hit),
        .tstamp_val (MSR_DW'(tsc_cnt)),
        .evcnt_val  ({{RSV_W{1'b0}}, evt_cnt}),
        .evsel_val  (sel_view),
        .rdata      (msr_rdata)
    );

endmodule

// File: rtl/msr_counter_bank_chk.sv
module msr_counter_bank_chk
    import msr_cnt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MSR_AW-1:0] msr_addr,
    input logic [MSR_DW-1:0] msr_wdata,
    input logic              msr_wr,
    input logic              msr_rd,
    input logic [MSR_DW-1:0] msr_rdata,
    input logic              in_sys_mgmt,
    input logic              in_dbg_mgmt,
    input logic              in_suspend,
    input logic              run_in_sys_mgmt,
    input logic              run_in_dbg_mgmt,
    input logic              run_in_suspend,
    input logic              evt_valid,
    input logic [7:0]        evt_code,
    input logic [63:0]       tsc_cnt,
    input logic [39:0]       evt_cnt,
    input logic              sel_en,
    input logic [7:0]        sel_code
);

    logic wr_tsc, wr_evt, suppressed, ev_hit, mapped;

    assign wr_tsc     = msr_wr && (msr_addr == ADDR_TSTAMP);
    assign wr_evt     = msr_wr && (msr_addr == ADDR_EVCNT);
    assign suppressed = (in_sys_mgmt && !run_in_sys_mgmt) ||
                        (in_dbg_mgmt && !run_in_dbg_mgmt) ||
                        (in_suspend  && !run_in_suspend);
    assign ev_hit     = evt_valid && sel_en && (evt_code == sel_code);
    assign mapped     = (msr_addr == ADDR_TSTAMP) || (msr_addr == ADDR_EVCNT) ||
                        (msr_addr == ADDR_EVSEL);

    // R2
    a_r2_tsc_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tsc |=> tsc_cnt == {32'h0, $past(msr_wdata[31:0])});

    // R3
    a_r3_tsc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_tsc && !suppressed) |=> tsc_cnt == $past(tsc_cnt) + 64'd1);

    // R4
    a_r4_tsc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_tsc && suppressed) |=> $stable(tsc_cnt));

    // R5, R8
    a_r5_evt_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> evt_cnt == $past(msr_wdata[39:0]));

    // R5
    a_r5_evt_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && msr_addr == ADDR_EVCNT) |=> msr_rdata[63:40] == 24'h0);

    // R7, R9
    a_r7_evt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_evt && ev_hit) |=> evt_cnt == $past(evt_cnt) + 40'd1);

    // R7
    a_r7_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_evt && !ev_hit) |=> $stable(evt_cnt));

    // R10
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !mapped) |=> msr_rdata == 64'h0);

    // R10
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rd |=> msr_rdata == 64'h0);

endmodule

bind msr_counter_bank msr_counter_bank_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .msr_addr        (msr_addr),
    .msr_wdata       (msr_wdata),
    .msr_wr          (msr_wr),
    .msr_rd          (msr_rd),
    .msr_rdata       (msr_rdata),
    .in_sys_mgmt     (in_sys_mgmt),
    .in_dbg_mgmt     (in_dbg_mgmt),
    .in_suspend      (in_suspend),
    .run_in_sys_mgmt (run_in_sys_mgmt),
    .run_in_dbg_mgmt (run_in_dbg_mgmt),
    .run_in_suspend  (run_in_suspend),
    .evt_valid       (evt_valid),
    .evt_code        (evt_code),
    .tsc_cnt         (tsc_cnt),
    .evt_cnt         (evt_cnt),
    .sel_en          (sel_en),
    .sel_code        (sel_code)
);

// File: tb/msr_counter_bank_test.sv
module msr_counter_bank_test;

    localparam logic [31:0] A_TS  = 32'h0000_0010;
    localparam logic [31:0] A_EV  = 32'h0000_00C1;
    localparam logic [31:0] A_SEL = 32'h0000_0186;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] msr_addr = '0;
    logic [63:0] msr_wdata = '0;
    logic        msr_wr = 1'b0;
    logic        msr_rd = 1'b0;
    logic [63:0] msr_rdata;
    logic        in_sys_mgmt = 1'b0, in_dbg_mgmt = 1'b0, in_suspend = 1'b1;
    logic        run_in_sys_mgmt = 1'b0, run_in_dbg_mgmt = 1'b0, run_in_suspend = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_code = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    msr_counter_bank uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .msr_addr        (msr_addr),
        .msr_wdata       (msr_wdata),
        .msr_wr          (msr_wr),
        .msr_rd          (msr_rd),
        .msr_rdata       (msr_rdata),
        .in_sys_mgmt     (in_sys_mgmt),
        .in_dbg_mgmt     (in_dbg_mgmt),
        .in_suspend      (in_suspend),
        .run_in_sys_mgmt (run_in_sys_mgmt),
        .run_in_dbg_mgmt (run_in_dbg_mgmt),
        .run_in_suspend  (run_in_suspend),
        .evt_valid       (evt_valid),
        .evt_code        (evt_code)
    );

    function automatic logic [63:0] ts_after_load(input logic [63:0] w);
        return {32'h0, w[31:0]};
    endfunction

    function automatic bit ts_halted(input logic [2:0] act, input logic [2:0] keep);
        return |(act & ~keep);
    endfunction

    function automatic logic [63:0] ev_view(input logic [39:0] c);
        return {24'h0, c};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [31:0] a, input logic [63:0] d);
        msr_addr  = a;
        msr_wdata = d;
        msr_wr    = 1'b1;
        @(negedge clk);
        msr_wr    = 1'b0;
    endtask

    task automatic do_rd(input logic [31:0] a, output logic [63:0] d);
        msr_addr = a;
        msr_rd   = 1'b1;
        @(negedge clk);
        msr_rd   = 1'b0;
        d        = msr_rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] v, v2;
        logic [39:0] ev_exp;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state (timestamp held by suspend without permission)
        check("R1 rdata", msr_rdata, 64'h0);
        do_rd(A_TS, v);  check("R1 tstamp", v, 64'h0);
        do_rd(A_EV, v);  check("R1 evcnt", v, 64'h0);
        do_rd(A_SEL, v); check("R1 evsel", v, 64'h0);

        // R4: suspend without permission holds
        do_rd(A_TS, v);
        repeat (5) @(negedge clk);
        do_rd(A_TS, v2);
        check("R4 suspend hold", v2 - v, 64'h0);

        // R3: free run, K idle cycles -> K+1 steps between captures
        in_suspend = 1'b0;
        do_rd(A_TS, v);
        repeat (7) @(negedge clk);
        do_rd(A_TS, v2);
        check("R3 free run", v2 - v, 64'd8);

        // R4: random mode / permission mixes
        for (int i = 0; i < 16; i++) begin
            logic [2:0] act, keep;
            int k;
            act  = 3'($urandom_range(0, 7));
            keep = 3'($urandom_range(0, 7));
            k    = int'($urandom_range(1, 20));
            {in_suspend, in_dbg_mgmt, in_sys_mgmt}          = act;
            {run_in_suspend, run_in_dbg_mgmt, run_in_sys_mgmt} = keep;
            do_rd(A_TS, v);
            repeat (k) @(negedge clk);
            do_rd(A_TS, v2);
            check("R4 mode mix", v2 - v, ts_halted(act, keep) ? 64'd0 : 64'(k + 1));
        end
        {in_suspend, in_dbg_mgmt, in_sys_mgmt} = 3'b000;

        // R2, R8: load clears upper half; write wins over the same-cycle step
        do_wr(A_TS, 64'hDEAD_BEEF_1234_5678);
        do_rd(A_TS, v);
        check("R2 R8 tstamp load", v, ts_after_load(64'hDEAD_BEEF_1234_5678));

        // R3: carry from bit 31 into bit 32
        do_wr(A_TS, 64'hFFFF_FFFF_FFFF_FFFF);
        do_rd(A_TS, v);
        check("R2 load all-ones low", v, 64'h0000_0000_FFFF_FFFF);
        do_rd(A_TS, v);
        check("R3 carry", v, 64'h0000_0001_0000_0000);

        // R6: select readback keeps bits 7:0 and bit 8 only
        do_wr(A_SEL, 64'hFFFF_FFFF_FFFF_FF5A);
        do_rd(A_SEL, v);
        check("R6 select view", v, 64'h0000_0000_0000_015A);

        // R5: reserved bits dropped
        do_wr(A_EV, 64'hABCD_EF12_3456_789A);
        do_rd(A_EV, v);
        check("R5 evcnt load", v, 64'h0000_0012_3456_789A);

        // R7: random event streams with the counter cleared
        do_wr(A_EV, 64'h0);
        ev_exp = '0;
        for (int i = 0; i < 400; i++) begin
            evt_valid = 1'($urandom_range(0, 1));
            evt_code  = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 255)) : 8'h5A;
            if (evt_valid && evt_code == 8'h5A) ev_exp++;
            @(negedge clk);
        end
        evt_valid = 1'b0;
        do_rd(A_EV, v);
        check("R7 counted events", v, ev_view(ev_exp));

        // R7: disabled select ignores matching events
        do_wr(A_SEL, 64'h0000_0000_0000_005A);
        for (int i = 0; i < 50; i++) begin
            evt_valid = 1'b1;
            evt_code  = 8'h5A;
            @(negedge clk);
        end
        evt_valid = 1'b0;
        do_rd(A_EV, v);
        check("R7 disabled hold", v, ev_view(ev_exp));

        // R7: code mismatch ignored while enabled
        do_wr(A_SEL, 64'h0000_0000_0000_015A);
        evt_valid = 1'b1; evt_code = 8'hA5;
        repeat (10) @(negedge clk);
        evt_valid = 1'b0;
        do_rd(A_EV, v);
        check("R7 mismatch hold", v, ev_view(ev_exp));

        // R8: event write with a qualified event in the same cycle
        evt_valid = 1'b1; evt_code = 8'h5A;
        do_wr(A_EV, 64'h0000_0000_0000_1000);
        evt_valid = 1'b0;
        do_rd(A_EV, v);
        check("R8 evt write wins", v, 64'h1000);

        // R9: wrap
        do_wr(A_EV, 64'h0000_00FF_FFFF_FFFF);
        evt_valid = 1'b1; evt_code = 8'h5A;
        @(negedge clk);
        evt_valid = 1'b0;
        do_rd(A_EV, v);
        check("R9 evt wrap", v, 64'h0);

        // R10: read in the write cycle returns the old value
        msr_addr = A_EV; msr_wdata = 64'h77; msr_wr = 1'b1; msr_rd = 1'b1;
        @(negedge clk);
        msr_wr = 1'b0; msr_rd = 1'b0;
        check("R10 read before write", msr_rdata, 64'h0);
        do_rd(A_EV, v);
        check("R10 write landed", v, 64'h77);

        // R10: idle cycle returns zero
        @(negedge clk);
        check("R10 idle zero", msr_rdata, 64'h0);

        // R10: unhandled addresses
        do_wr(32'h0000_0011, 64'hFFFF_FFFF_FFFF_FFFF);
        do_wr(32'h0000_0187, 64'h0);
        do_rd(A_EV, v);  check("R10 unmapped write evcnt", v, 64'h77);
        do_rd(A_SEL, v); check("R10 unmapped write evsel", v, 64'h15A);
        do_rd(32'h0000_0011, v); check("R10 unmapped read", v, 64'h0);
        do_rd(32'h0000_00C0, v); check("R10 unmapped read 2", v, 64'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule